// File: doc/BRIEF.md
# Self-Running Scan Chain Tester

This block holds two small state machines, a 3-bit one and a 2-bit one, whose five state flip-flops are all mux-D scan cells joined into one 5-bit chain. All cells run on one clock with no gating. In normal operation the machines step every clock from their functional next-state logic. Their only external input is registered before it reaches that logic, and the register is forced to zero during test so that the input is controllable.

A pulse on `start` hands the chain to a built-in sequencer. For each of seven fixed vectors, it shifts the vector in bit by bit, gives one functional capture clock, and then shifts the captured response out while the next vector goes in. It checks every response bit against a table of expected values. A sticky fail flag records any mismatch. The whole run takes 7×(5+1)+5 = 47 cycles, after which `done` is raised.

Top module: `scan_test_seq`

## Requirements
- R1: While `rstN` is low, `fsmState` is 0 and `busy`, `done` and `fail` are 0.
- R2: In normal mode the 3-bit machine a = `fsmState[2:0]` steps to {a[1], a[0], a[2]^a[1]^x}, where x is `extIn` registered one clock earlier.
- R3: In normal mode the 2-bit machine b = `fsmState[4:3]` steps to {b[0], ~b[1]^x}, with the same x as R2.
- R4: `start` seen high while idle raises `busy` on the next edge. `busy` then stays high for exactly 47 cycles, after which `busy` falls and `done` rises in the same edge. `done` holds until the next start.
- R5: On a shift clock the chain moves toward bit 0: the serial input enters bit 4 and bit 0 is the serial output. Vector bit 0 is shifted first, so after five shifts the vector sits in `fsmState` bit for bit.
- R6: After each five shifts, exactly one capture clock applies the R2/R3 next-state logic with x forced to 0.
- R7: Vectors run in this order: one-hot with bit 0 set, then bit 1 up to bit 4, then all zeros, then all ones. The expected responses are 0x0A, 0x0D, 0x09, 0x18, 0x00, 0x08, 0x16. The last five shifts load zeros, so `fsmState` is 0 when `done` rises.
- R8: Each response bit is compared on the serial output before the edge that advances it. `fail` is cleared at start, set by any mismatch and sticky, so a correct design ends with `fail` = 0.
- R9: `start` pulses while `busy` is high are ignored and do not lengthen or restart the run.
- R10: `extIn` has no effect during a test: responses and the 47-cycle length are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single common clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a self-test when idle |
| extIn | input | 1 | Functional input to both machines |
| busy | output | 1 | Self-test running |
| done | output | 1 | Self-test finished |
| fail | output | 1 | Sticky response mismatch |
| fsmState | output | 5 | Chain contents, {b[1:0], a[2:0]} |

## Verification
Two things share a cycle in every shift clock after the first phase: a bit of the next vector enters the chain, and a bit of the previous response leaves it and is compared.

The bench tracks the chain contents after every fifth shift and after every capture, so the loaded vector and the captured response are both checked against hand-computed values. It then relies on the fail flag to show that the overlapped outgoing bits matched.

A second run drives `start` and `extIn` high during a middle phase. This shows that neither disturbs the overlapped stream or the 47-cycle length.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  localparam int A_W         = 3;
  localparam int B_W         = 2;
  localparam int CHAIN_W     = A_W + B_W;
  localparam int NUM_VEC     = CHAIN_W + 2;
  localparam int PHASE_LEN   = CHAIN_W + 1;
  localparam int TEST_CYCLES = NUM_VEC * PHASE_LEN + CHAIN_W;
  localparam int VEC_W       = $clog2(NUM_VEC + 1);
  localparam int POS_W       = $clog2(PHASE_LEN);

  typedef struct packed {
    logic testMode;
    logic scanEn;
    logic scanBit;
  } scanCtrl_t;

  // Functional next state of both machines: {b[1:0], a[2:0]}
  function automatic logic [CHAIN_W-1:0] nextState(input logic [CHAIN_W-1:0] s, input logic x);
    logic [A_W-1:0] a;
    logic [B_W-1:0] b;
    a = s[A_W-1:0];
    b = s[CHAIN_W-1:A_W];
    return {b[0], ~b[1] ^ x, a[1], a[0], a[2] ^ a[1] ^ x};
  endfunction

  // Vector idx: one-hot for idx < CHAIN_W, then all zeros, then all ones
  function automatic logic [CHAIN_W-1:0] vectorOf(input int idx);
    logic [CHAIN_W-1:0] v;
    for (int k = 0; k < CHAIN_W; k++) v[k] = (idx == k) || (idx == CHAIN_W + 1);
    return v;
  endfunction
endpackage

// File: rtl/scan_datapath.sv
module scan_datapath
  import scan_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  scanCtrl_t          ctrl,
  input  logic               extIn,
  output logic               scanOut,
  output logic [CHAIN_W-1:0] state
);
  logic               inReg;
  logic [CHAIN_W-1:0] funcNext;

  // External input registered; forced to zero while under test
  always_ff @(posedge clk) begin
    if (!rstN)              inReg <= 1'b0;
    else if (ctrl.testMode) inReg <= 1'b0;
    else                    inReg <= extIn;
  end

  always_comb funcNext = nextState(state, inReg);

  // One mux-D scan cell per state bit
  for (genvar i = 0; i < CHAIN_W; i++) begin : g_cell
    logic chainSrc;
    if (i == CHAIN_W - 1) begin : g_head
      always_comb chainSrc = ctrl.scanBit;
    end else begin : g_link
      always_comb chainSrc = state[i+1];
    end
    always_ff @(posedge clk) begin
      if (!rstN) state[i] <= 1'b0;
      else       state[i] <= ctrl.scanEn ? chainSrc : funcNext[i];
    end
  end

  assign scanOut = state[0];

  assert_shift_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.scanEn |=> (state[CHAIN_W-2:0] == $past(state[CHAIN_W-1:1])) &&
                    (state[CHAIN_W-1] == $past(ctrl.scanBit)));

  assert_input_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.testMode |=> inReg == 1'b0);
endmodule

// File: rtl/scan_control.sv
module scan_control
  import scan_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      scanOut,
  output scanCtrl_t ctrl,
  output logic      busy,
  output logic      done,
  output logic      fail
);
  logic [VEC_W-1:0]   vecIdx;
  logic [POS_W-1:0]   bitPos;
  logic [CHAIN_W-1:0] curVec;
  logic [CHAIN_W-1:0] expResp;
  logic               shifting;
  logic               lastCycle;
  logic               mismatch;

  always_comb begin
    shifting  = busy && (int'(bitPos) < CHAIN_W);
    lastCycle = busy && (int'(vecIdx) == NUM_VEC) && (int'(bitPos) == CHAIN_W - 1);
    curVec    = (int'(vecIdx) < NUM_VEC) ? vectorOf(int'(vecIdx)) : '0;
    expResp   = nextState(vectorOf(int'(vecIdx) - 1), 1'b0);
    mismatch  = shifting && (vecIdx != '0) && (scanOut != expResp[bitPos[$clog2(CHAIN_W)-1:0]]);
    ctrl.testMode = busy;
    ctrl.scanEn   = shifting;
    ctrl.scanBit  = shifting && curVec[bitPos[$clog2(CHAIN_W)-1:0]];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0; done <= 1'b0; fail <= 1'b0;
      vecIdx <= '0; bitPos <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1; done <= 1'b0; fail <= 1'b0;
        vecIdx <= '0; bitPos <= '0;
      end
    end else begin
      if (mismatch) fail <= 1'b1;
      if (lastCycle) begin
        busy <= 1'b0;
        done <= 1'b1;
      end else if (int'(bitPos) == PHASE_LEN - 1) begin
        bitPos <= '0;
        vecIdx <= vecIdx + 1'b1;
      end else begin
        bitPos <= bitPos + 1'b1;
      end
    end
  end

  assert_busy_done_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !lastCycle) |=> busy);

  assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && fail) |=> fail);

  assert_single_capture_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !ctrl.scanEn) |=> ctrl.scanEn);
endmodule

// File: rtl/scan_test_seq.sv
module scan_test_seq
  import scan_seq_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               extIn,
  output logic               busy,
  output logic               done,
  output logic               fail,
  output logic [CHAIN_W-1:0] fsmState
);
  scanCtrl_t ctrl;
  logic      scanOut;

  scan_control i_control (
    .clk(clk), .rstN(rstN), .start(start), .scanOut(scanOut),
    .ctrl(ctrl), .busy(busy), .done(done), .fail(fail)
  );

  scan_datapath i_datapath (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .extIn(extIn),
    .scanOut(scanOut), .state(fsmState)
  );
endmodule

// File: tb/test_scan_test_seq.sv
module test_scan_test_seq;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       start = 1'b0;
  logic       extIn = 1'b0;
  logic       busy, done, fail;
  logic [4:0] fsmState;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  scan_test_seq i_scan_test_seq (
    .clk(clk), .rstN(rstN), .start(start), .extIn(extIn),
    .busy(busy), .done(done), .fail(fail), .fsmState(fsmState)
  );

  localparam logic [0:15] IN_SEQ = 16'b0110_1001_1100_0101;
  localparam logic [4:0] RESP [7] = '{5'h0A, 5'h0D, 5'h09, 5'h18, 5'h00, 5'h08, 5'h16};

  function automatic logic [4:0] model(input logic [4:0] s, input logic x);
    return {s[3], ~s[4] ^ x, s[1], s[0], s[2] ^ s[1] ^ x};
  endfunction

  function automatic logic [4:0] vecOf(input int v);
    if (v < 5) return 5'(1 << v);
    if (v == 5) return 5'h00;
    return 5'h1F;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic runTest(input logic disturb);
    @(negedge clk); start = 1'b1;
    @(posedge clk);
    @(negedge clk); start = 1'b0;
    check("R4 busy rises", busy, 1);
    for (int v = 0; v < 7; v++) begin
      if (disturb && v == 2) begin start = 1'b1; extIn = 1'b1; end
      if (disturb && v == 3) begin start = 1'b0; extIn = 1'b0; end
      repeat (5) @(posedge clk);
      @(negedge clk);
      check("R5 vector loaded", fsmState, vecOf(v));
      @(posedge clk);
      @(negedge clk);
      check("R6 R7 captured response", fsmState, RESP[v]);
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R4 busy before last", {busy, done}, 2'b10);
    @(posedge clk);
    @(negedge clk);
    check("R4 done after 47", {busy, done}, 2'b01);
    check("R8 fail clear", fail, 0);
    check("R7 chain flushed", fsmState, 0);
    @(posedge clk);
    @(negedge clk);
    check("R4 done holds", done, 1);
    check("R2 R3 normal resumes", fsmState, 5'h08);
  endtask

  initial begin
    logic [4:0] mState;
    logic       mIn;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset state", {fsmState, busy, done, fail}, 0);
    rstN = 1'b1;
    mState = '0; mIn = 1'b0;
    for (int i = 0; i < 16; i++) begin
      extIn = IN_SEQ[i];
      @(posedge clk);
      mState = model(mState, mIn);
      mIn = IN_SEQ[i];
      @(negedge clk);
      check("R2 R3 functional step", fsmState, mState);
    end
    extIn = 1'b0;
    runTest(1'b0);
    runTest(1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule